// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block produces gated copies of two derived clocks and starts and stops them without runt pulses. A single master clock drives everything. Inside the block, two enable-based dividers make a fast CPU-domain level and a slower PCI-domain level. The PCI domain runs at one half or one third of the CPU rate. The CPU divider ratio comes from a strap that is sampled while reset is high. The PCI divider ratio is fixed. Both dividers start from the same reset, so every PCI rising edge falls on a CPU rising edge.

Three active-low requests control the outputs. `cpu_stop_n` parks the CPU copies. `pci_stop_n` parks the stoppable PCI copies but never the free-running one. `pwr_dwn_n` parks every output. Each request first passes a two-flop synchronizer. It then moves through a two-entry pipeline that advances only on that domain's rising boundary, so a request takes effect two or three domain cycles after it arrives. The gate changes only in the master cycle in which the divided level is about to rise. As a result an output pulse is either a complete high phase or no pulse at all.

Releasing power-down starts a restart counter of `RESTART_CYC` master cycles. The outputs start again only after that delay, each beginning with a full cycle. An output-enable strap is sampled during reset and drives `out_en`, which marks whether the outputs should be driven or tri-stated.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, and in the first master cycle after it falls, every clock output is low.
- R2: The CPU output period is 2*HALF_FAST master cycles when `sel_fast_strap` was 1 during reset, and 2*HALF_SLOW when it was 0. The PCI output period is 2*PCI_HALF master cycles. Every PCI rising edge falls on the same master edge as a CPU rising edge.
- R3: All bits of `cpu_clk` are equal, and all bits of `pci_clk` are equal. When no stop is active, `pci_clk` equals `pci_clk_free`.
- R4: Every high pulse on any output lasts exactly one half period of its domain. Every low interval lasts at least one half period.
- R5: After `cpu_stop_n` falls, the CPU outputs give one or two more rising edges and then stay low. The PCI outputs keep toggling.
- R6: After `cpu_stop_n` rises, the first CPU rising edge comes between one and three CPU periods later.
- R7: After `pci_stop_n` falls, `pci_clk` gives one or two more rising edges and then stays low. `pci_clk_free` and `cpu_clk` keep toggling.
- R8: After `pci_stop_n` rises, the first `pci_clk` rising edge comes between one and three PCI periods later.
- R9: After `pwr_dwn_n` falls, each output gives at most two more rising edges and then stays low, whatever the stop inputs do.
- R10: After `pwr_dwn_n` rises, no output rises for at least RESTART_CYC master cycles. All outputs rise again within RESTART_CYC + 3 PCI periods + 4 master cycles.
- R11: `out_en` holds the value that `oe_strap` had during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| sel_fast_strap | input | 1 | 1 selects the fast CPU ratio, 0 the slow one |
| oe_strap | input | 1 | Output-enable strap |
| cpu_stop_n | input | 1 | Active-low CPU stop request, asynchronous |
| pci_stop_n | input | 1 | Active-low stop request for the stoppable PCI copies |
| pwr_dwn_n | input | 1 | Active-low power-down request |
| cpu_clk | output | N_CPU | Gated CPU clock copies |
| pci_clk | output | N_PCI | Gated, stoppable PCI clock copies |
| pci_clk_free | output | 1 | PCI copy that ignores the PCI stop request |
| out_en | output | 1 | Output drive enable (0 = tri-state) |

## Verification
A wrong gate pipeline shows at the ports as the wrong number of trailing or leading pulses. The bench sees this within three domain periods of the request. A gate that changes outside the low phase shows up as a shortened high pulse on the next divided edge. A wrong divider count or a misaligned reset phase changes the measured period or breaks PCI/CPU edge coincidence within one PCI period. A wrong restart counter shows as an early or late first edge once power-down is released.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_DOWN = 2'd1,
    PD_WAKE = 2'd2
  } pd_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];

endmodule

// File: rtl/clkstop_div.sv
module clkstop_div #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] half,
  output logic          lvl,
  output logic          lvl_nxt,
  output logic          rise
);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == half - CW'(1));
  assign lvl_nxt = wrap ? ~lvl : lvl;
  assign rise    = wrap & ~lvl;

  // Level starts high so that both dividers share rising edges at 2*half multiples
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int N = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         rise,
  input  logic         lvl,
  input  logic         lvl_nxt,
  output logic [N-1:0] clk_out
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;
  logic              gate_nxt;

  generate
    if (STAGES == 1) begin : g_one
      assign pipe_d = run;
    end else begin : g_many
      assign pipe_d = {pipe_q[STAGES-2:0], run};
    end
  endgenerate

  assign gate_nxt = rise ? pipe_d[STAGES-1] : pipe_q[STAGES-1];

  // Request pipeline advances only at the low-to-high boundary of the domain
  always_ff @(posedge clk) begin
    if (rst)       pipe_q <= '0;
    else if (rise) pipe_q <= pipe_d;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) clk_out[gi] <= 1'b0;
      else     clk_out[gi] <= lvl_nxt & gate_nxt;
    end
  end

  AST_GATE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(pipe_q[STAGES-1]) |-> !$past(lvl)) else $error("gate moved in high phase"); // R4

  AST_FALL_WITH_LVL: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out[0]) |-> $fell(lvl)) else $error("output cut short"); // R4

endmodule

// File: rtl/clkstop_pwr.sv
module clkstop_pwr
  import clkstop_pkg::*;
#(
  parameter int RESTART_CYC = 1200000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_s,
  output logic run_ok
);

  localparam int CNT_W = (RESTART_CYC < 2) ? 1 : $clog2(RESTART_CYC + 1);

  pd_state_t        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PD_RUN;
      cnt   <= '0;
    end else if (!pd_n_s) begin
      state <= PD_DOWN;
      cnt   <= '0;
    end else begin
      case (state)
        PD_DOWN: begin
          state <= PD_WAKE;
          cnt   <= '0;
        end
        PD_WAKE: begin
          if (cnt == CNT_W'(RESTART_CYC - 1)) state <= PD_RUN;
          else                                cnt   <= cnt + CNT_W'(1);
        end
        default: state <= PD_RUN;
      endcase
    end
  end

  assign run_ok = (state == PD_RUN);

  AST_DOWN_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !pd_n_s |=> state == PD_DOWN) else $error("power-down not entered"); // R9

  AST_WAKE_LEN: assert property (@(posedge clk) disable iff (rst)
    (state == PD_RUN && $past(state) == PD_WAKE) |-> $past(cnt) == CNT_W'(RESTART_CYC - 1))
    else $error("restart delay too short"); // R10

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU       = 2,
  parameter int N_PCI       = 5,
  parameter int HALF_FAST   = 2,
  parameter int HALF_SLOW   = 3,
  parameter int PCI_HALF    = 6,
  parameter int RESTART_CYC = 1200000,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_fast_strap,
  input  logic             oe_strap,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dwn_n,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_clk_free,
  output logic             out_en
);

  localparam int HMAX = max3(HALF_FAST, HALF_SLOW, PCI_HALF);
  localparam int CW   = $clog2(HMAX + 1);

  logic          sel_q;
  logic          oe_q;
  logic [CW-1:0] cpu_half;
  logic          cpu_lvl, cpu_nxt, cpu_rise;
  logic          pci_lvl, pci_nxt, pci_rise;
  logic [2:0]    req_s;
  logic          run_ok;
  logic [0:0]    free_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel_fast_strap;
      oe_q  <= oe_strap;
    end
  end

  assign out_en   = oe_q;
  assign cpu_half = sel_q ? CW'(HALF_FAST) : CW'(HALF_SLOW);

  clkstop_div #(.CW(CW)) u_cpu_div (
    .clk(clk), .rst(rst), .half(cpu_half),
    .lvl(cpu_lvl), .lvl_nxt(cpu_nxt), .rise(cpu_rise)
  );

  clkstop_div #(.CW(CW)) u_pci_div (
    .clk(clk), .rst(rst), .half(CW'(PCI_HALF)),
    .lvl(pci_lvl), .lvl_nxt(pci_nxt), .rise(pci_rise)
  );

  clkstop_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst),
    .din({pwr_dwn_n, pci_stop_n, cpu_stop_n}),
    .dout(req_s)
  );

  clkstop_pwr #(.RESTART_CYC(RESTART_CYC)) u_pwr (
    .clk(clk), .rst(rst), .pd_n_s(req_s[2]), .run_ok(run_ok)
  );

  clkstop_gate #(.N(N_CPU), .STAGES(GATE_STAGES)) u_cpu_gate (
    .clk(clk), .rst(rst), .run(req_s[0] & run_ok), .rise(cpu_rise),
    .lvl(cpu_lvl), .lvl_nxt(cpu_nxt), .clk_out(cpu_clk)
  );

  clkstop_gate #(.N(N_PCI), .STAGES(GATE_STAGES)) u_pci_gate (
    .clk(clk), .rst(rst), .run(req_s[1] & run_ok), .rise(pci_rise),
    .lvl(pci_lvl), .lvl_nxt(pci_nxt), .clk_out(pci_clk)
  );

  clkstop_gate #(.N(1), .STAGES(GATE_STAGES)) u_free_gate (
    .clk(clk), .rst(rst), .run(run_ok), .rise(pci_rise),
    .lvl(pci_lvl), .lvl_nxt(pci_nxt), .clk_out(free_vec)
  );

  assign pci_clk_free = free_vec[0];

  initial begin
    AST_RATIO_PARAM: assert (PCI_HALF == 3 * HALF_FAST && PCI_HALF == 2 * HALF_SLOW)
      else $error("divider ratios must be 2:1 and 3:1"); // R2
  end

  AST_PCI_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_lvl) |-> $rose(cpu_lvl)) else $error("PCI edge off CPU edge"); // R2

  AST_CPU_COPIES: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk == '0) || (cpu_clk == '1)) else $error("CPU copies differ"); // R3

endmodule

// File: tb/clkstop_ctrl_bench.sv
module clkstop_ctrl_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int N_CPU       = 2;
  localparam int N_PCI       = 5;
  localparam int HALF_FAST   = 2;
  localparam int HALF_SLOW   = 3;
  localparam int PCI_HALF    = 6;
  localparam int RESTART_CYC = 50;
  localparam int PP          = 2 * PCI_HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_fast_strap = 1'b1;
  logic oe_strap = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic pci_stop_n = 1'b1;
  logic pwr_dwn_n = 1'b1;
  logic [N_CPU-1:0] cpu_clk;
  logic [N_PCI-1:0] pci_clk;
  logic pci_clk_free;
  logic out_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  int chalf = HALF_FAST;
  int rises [3];
  int hi_run [3];
  int lo_run [3];
  bit prev [3];
  bit rise_now [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkstop_ctrl #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW),
    .PCI_HALF(PCI_HALF), .RESTART_CYC(RESTART_CYC)
  ) u_clkstop_ctrl (
    .clk(clk), .rst(rst), .sel_fast_strap(sel_fast_strap), .oe_strap(oe_strap),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dwn_n(pwr_dwn_n),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_clk_free(pci_clk_free), .out_en(out_en)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: rising edges and pulse widths (R4), sampled at the falling edge
  always @(negedge clk) begin
    bit cur [3];
    int hv [3];
    cur[0] = cpu_clk[0]; cur[1] = pci_clk[0]; cur[2] = pci_clk_free;
    hv[0] = chalf; hv[1] = PCI_HALF; hv[2] = PCI_HALF;
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        hi_run[c] = 0; lo_run[c] = 1000; prev[c] = 0; rise_now[c] = 0;
      end
    end else begin
      cyc++;
      for (int c = 0; c < 3; c++) begin
        rise_now[c] = cur[c] && !prev[c];
        if (rise_now[c]) begin
          rises[c]++;
          check("R4 low gap", lo_run[c] >= hv[c], lo_run[c], hv[c]);
          hi_run[c] = 1;
        end else if (!cur[c] && prev[c]) begin
          check("R4 high width", hi_run[c] == hv[c], hi_run[c], hv[c]);
          lo_run[c] = 1;
        end else if (cur[c]) hi_run[c]++;
        else lo_run[c]++;
        prev[c] = cur[c];
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_rise(input int ch, input int maxc, output int lat);
    lat = 0;
    do begin
      tick(1);
      lat++;
    end while (!rise_now[ch] && lat < maxc);
  endtask

  task automatic do_reset(input bit fast, input bit oe);
    rst = 1'b1; sel_fast_strap = fast; oe_strap = oe;
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dwn_n = 1'b1;
    tick(6);
    check("R1 low in reset", cpu_clk == '0 && pci_clk == '0 && !pci_clk_free,
          {cpu_clk, pci_clk, pci_clk_free}, 0);
    chalf = fast ? HALF_FAST : HALF_SLOW;
    rst = 1'b0;
    tick(1);
    check("R1 low after reset", cpu_clk == '0 && pci_clk == '0 && !pci_clk_free,
          {cpu_clk, pci_clk, pci_clk_free}, 0);
    check("R11 out_en", out_en == oe, out_en, oe);
  endtask

  task automatic t_freq();
    int lat;
    int t0;
    int bad_align;
    int bad_copy;
    tick(40);
    wait_rise(0, 100, lat);
    t0 = cyc;
    wait_rise(0, 100, lat);
    check("R2 cpu period", cyc - t0 == 2 * chalf, cyc - t0, 2 * chalf);
    wait_rise(2, 100, lat);
    t0 = cyc;
    wait_rise(2, 100, lat);
    check("R2 pci period", cyc - t0 == PP, cyc - t0, PP);
    bad_align = 0;
    bad_copy = 0;
    for (int i = 0; i < 4 * PP; i++) begin
      tick(1);
      if (rise_now[2] && !rise_now[0]) bad_align++;
      if (!(cpu_clk == '0 || cpu_clk == '1) || !(pci_clk == '0 || pci_clk == '1) ||
          pci_clk[0] != pci_clk_free) bad_copy++;
    end
    check("R2 edge alignment", bad_align == 0, bad_align, 0);
    check("R3 copies equal", bad_copy == 0, bad_copy, 0);
  endtask

  task automatic t_cpu_stop();
    int p;
    int r0;
    int f0;
    int lat;
    p = 2 * chalf;
    tick(20);
    r0 = rises[0]; f0 = rises[2];
    cpu_stop_n = 1'b0;
    tick(3 * p);
    check("R5 trailing pulses", rises[0] - r0 >= 1 && rises[0] - r0 <= 2, rises[0] - r0, 2);
    r0 = rises[0];
    tick(8 * p);
    check("R5 cpu held", rises[0] == r0 && cpu_clk == '0, rises[0] - r0, 0);
    check("R5 pci unaffected", rises[2] - f0 >= 2, rises[2] - f0, 2);
    cpu_stop_n = 1'b1;
    wait_rise(0, 4 * p, lat);
    check("R6 restart latency", lat >= p && lat <= 3 * p, lat, 3 * p);
  endtask

  task automatic t_pci_stop();
    int r0;
    int f0;
    int c0;
    int lat;
    tick(20);
    r0 = rises[1]; f0 = rises[2]; c0 = rises[0];
    pci_stop_n = 1'b0;
    tick(3 * PP);
    check("R7 trailing pulses", rises[1] - r0 >= 1 && rises[1] - r0 <= 2, rises[1] - r0, 2);
    r0 = rises[1]; f0 = rises[2];
    tick(8 * PP);
    check("R7 pci held", rises[1] == r0 && pci_clk == '0, rises[1] - r0, 0);
    check("R7 free runs", rises[2] - f0 >= 7, rises[2] - f0, 8);
    check("R7 cpu runs", rises[0] - c0 >= 20, rises[0] - c0, 20);
    pci_stop_n = 1'b1;
    wait_rise(1, 4 * PP, lat);
    check("R8 restart latency", lat >= PP && lat <= 3 * PP, lat, 3 * PP);
  endtask

  task automatic t_pwr_down();
    int r0 [3];
    int first [3];
    int t;
    int bound;
    tick(20);
    for (int c = 0; c < 3; c++) r0[c] = rises[c];
    pwr_dwn_n = 1'b0;
    tick(3 * PP);
    for (int c = 0; c < 3; c++)
      check("R9 at most two trailing", rises[c] - r0[c] <= 2, rises[c] - r0[c], 2);
    for (int c = 0; c < 3; c++) r0[c] = rises[c];
    pci_stop_n = 1'b0;
    tick(2 * PP);
    pci_stop_n = 1'b1;
    cpu_stop_n = 1'b0;
    tick(PP);
    cpu_stop_n = 1'b1;
    tick(2 * PP);
    check("R9 all held", rises[0] == r0[0] && rises[1] == r0[1] && rises[2] == r0[2] &&
          cpu_clk == '0 && pci_clk == '0 && !pci_clk_free,
          rises[0] + rises[1] + rises[2] - r0[0] - r0[1] - r0[2], 0);
    bound = RESTART_CYC + 3 * PP + 4;
    for (int c = 0; c < 3; c++) first[c] = -1;
    pwr_dwn_n = 1'b1;
    t = 0;
    while (t < bound + 10 && (first[0] < 0 || first[1] < 0 || first[2] < 0)) begin
      tick(1);
      t++;
      for (int c = 0; c < 3; c++) if (rise_now[c] && first[c] < 0) first[c] = t;
    end
    for (int c = 0; c < 3; c++) begin
      check("R10 not early", first[c] >= RESTART_CYC, first[c], RESTART_CYC);
      check("R10 not late", first[c] >= 0 && first[c] <= bound, first[c], bound);
    end
  endtask

  initial begin
    do_reset(1'b1, 1'b1);
    t_freq();
    t_cpu_stop();
    t_pci_stop();
    t_pwr_down();
    do_reset(1'b0, 1'b0);
    t_freq();
    t_cpu_stop();
    tick(10);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule